// File: doc/BRIEF.md
# Modem Control and Status Unit

This block sits beside the register file of a 16550-style serial port. It holds the writable modem control bits and turns them into the two handshake outputs, Data Terminal Ready and Request To Send. Both outputs are active low on the pins, so a 1 in the register drives the pin to 0. It also watches the four modem status inputs (Clear To Send, Data Set Ready, Ring Indicator, Data Carrier Detect) and returns an 8-bit status value. The upper half of that value shows the present asserted level of each line. The lower half holds sticky change flags. Any flag that is set raises a modem interrupt request.

The status inputs are asynchronous. Each passes through a synchronizer chain before any edge detection. A loopback control bit reroutes the control bits onto the status side, so software can exercise the whole path without a cable. The same bit is brought out as a select for the serial data path outside this block. Register address decoding and the interrupt priority encoder are outside this block: the unit sees only a write strobe with data for the control register and a read strobe for the status value.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the stored control bits are all 0. dtr_o and rts_o are 1, loopback_o is 0, status bits 3..0 are 0 and irq_o is 0.
- R2: dtr_o is the inverse of stored control bit 0, and rts_o is the inverse of stored control bit 1. Both follow from the edge on which ctrl_we_i is high.
- R3: loopback_o equals stored control bit 4. Written bits 7..5 have no effect on any output.
- R4: With loopback off, status bits 4, 5, 6 and 7 equal the inverse of the CTS, DSR, RI and DCD input pins respectively. Each reflects its pin two clock edges after the pin changes.
- R5: With loopback on, status bit 4 equals control bit 1, bit 5 equals control bit 0, bit 6 equals control bit 2 and bit 7 equals control bit 3. The pins are then ignored.
- R6: Status bits 0, 1 and 3 are set when the asserted level of CTS, DSR or DCD respectively changes in either direction. The asserted level is the one reported in status bits 4, 5 and 7.
- R7: Status bit 2 is set only when the RI line goes from low to high, which shows as status bit 6 going from 1 to 0. A high-to-low RI change leaves bit 2 alone.
- R8: A cycle with status_rd_i high clears status bits 3..0 on the next edge. A change detected on that same edge still sets its bit.
- R9: irq_o is 1 exactly when any of status bits 3..0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control bits |
| ctrl_wdata_i | input | 8 | Control value to store |
| status_rd_i | input | 1 | Status read strobe, clears change flags |
| line_cts_i | input | 1 | Clear To Send pin level (asynchronous) |
| line_dsr_i | input | 1 | Data Set Ready pin level (asynchronous) |
| line_ri_i | input | 1 | Ring Indicator pin level (asynchronous) |
| line_dcd_i | input | 1 | Data Carrier Detect pin level (asynchronous) |
| dtr_o | output | 1 | Data Terminal Ready pin, active low |
| rts_o | output | 1 | Request To Send pin, active low |
| status_o | output | 8 | Line levels in 7..4, change flags in 3..0 |
| irq_o | output | 1 | Modem status interrupt request |
| loopback_o | output | 1 | Loopback select for the serial data path |

## Verification
The bench drives a seeded random mix of three stimuli: control writes with random bytes, random flips of the four pins, and status reads. A model compares the levels and sticky flags after each one. Writes with loopback on and off tell the pin route from the register route. Flips of each pin alone tell the any-edge detectors from the RI trailing-edge detector. Directed cases cover the reset state and a write with only bits 7..5 set. They also cover RI edges in both directions and a line change that lands on the same edge as a read, which separates a flag kept on collision from one lost to the clear.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // status line indices, in the order the status value reports them
   localparam int LINE_CTS  = 0;
   localparam int LINE_DSR  = 1;
   localparam int LINE_RI   = 2;
   localparam int LINE_DCD  = 3;
   localparam int NUM_LINES = 4;

   // control bit positions
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;
   localparam int CTRL_USED = 5;

   typedef enum logic {
      DET_ANY_EDGE = 1'b0,
      DET_TRAILING = 1'b1
   } det_kind_e;

   function automatic det_kind_e kind_of_line(input int idx);
      return (idx == LINE_RI) ? DET_TRAILING : DET_ANY_EDGE;
   endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int   WIDTH     = 4,
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mdm_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg #(
   parameter int BUS_W  = 8,
   parameter int KEEP_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [KEEP_W-1:0] ctrl_o
);
   if (KEEP_W > BUS_W) begin : g_bad_keep
      $error("mdm_ctrl_reg: KEEP_W exceeds BUS_W");
   end

   // bits above KEEP_W are dropped on write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_o <= '0;
      else if (we_i) ctrl_o <= wdata_i[KEEP_W-1:0];
   end
endmodule

// File: rtl/mdm_change_det.sv
module mdm_change_det
   import mdm_pkg::*;
#(
   parameter int N = NUM_LINES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level_i,
   input  logic         clear_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] level_q;
   logic [N-1:0] event_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      if (kind_of_line(i) == DET_TRAILING) begin : g_trail
         // asserted level dropping means the pin rose
         assign event_w[i] = level_q[i] & ~level_i[i];
      end else begin : g_any
         assign event_w[i] = level_q[i] ^ level_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_o[i] <= 1'b0;
         else        flag_o[i] <= (flag_o[i] & ~clear_i) | event_w[i];
      end
   end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BUS_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we_i,
   input  logic [BUS_W-1:0] ctrl_wdata_i,
   input  logic             status_rd_i,
   input  logic             line_cts_i,
   input  logic             line_dsr_i,
   input  logic             line_ri_i,
   input  logic             line_dcd_i,
   output logic             dtr_o,
   output logic             rts_o,
   output logic [2*NUM_LINES-1:0] status_o,
   output logic             irq_o,
   output logic             loopback_o
);
   if (BUS_W < CTRL_USED) begin : g_bad_bus
      $error("modem_ctl_stat: BUS_W too narrow for control bits");
   end

   logic [CTRL_USED-1:0] ctrl_q;
   logic [NUM_LINES-1:0] pins_w, pins_s, level_w, flags_w;

   mdm_ctrl_reg #(.BUS_W(BUS_W), .KEEP_W(CTRL_USED)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we_i(ctrl_we_i),
      .wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_q)
   );

   assign pins_w[LINE_CTS] = line_cts_i;
   assign pins_w[LINE_DSR] = line_dsr_i;
   assign pins_w[LINE_RI]  = line_ri_i;
   assign pins_w[LINE_DCD] = line_dcd_i;

   mdm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pins_w), .sync_o(pins_s)
   );

   logic [NUM_LINES-1:0] loop_w;
   assign loop_w[LINE_CTS] = ctrl_q[CB_RTS];
   assign loop_w[LINE_DSR] = ctrl_q[CB_DTR];
   assign loop_w[LINE_RI]  = ctrl_q[CB_OUT1];
   assign loop_w[LINE_DCD] = ctrl_q[CB_OUT2];

   assign level_w = ctrl_q[CB_LOOP] ? loop_w : ~pins_s;

   mdm_change_det #(.N(NUM_LINES)) u_det (
      .clk(clk), .rst_n(rst_n), .level_i(level_w),
      .clear_i(status_rd_i), .flag_o(flags_w)
   );

   assign dtr_o      = ~ctrl_q[CB_DTR];
   assign rts_o      = ~ctrl_q[CB_RTS];
   assign loopback_o = ctrl_q[CB_LOOP];
   assign status_o   = {level_w, flags_w};
   assign irq_o      = |flags_w;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int BUS_W       = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_we_i,
   input logic [BUS_W-1:0] ctrl_wdata_i,
   input logic             status_rd_i,
   input logic             line_cts_i,
   input logic             line_dsr_i,
   input logic             line_ri_i,
   input logic             line_dcd_i,
   input logic             dtr_o,
   input logic             rts_o,
   input logic [7:0]       status_o,
   input logic             irq_o,
   input logic             loopback_o
);
   assert_pin_invert_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we_i |=> (dtr_o == !$past(ctrl_wdata_i[0])) && (rts_o == !$past(ctrl_wdata_i[1])));

   assert_loop_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we_i |=> loopback_o == $past(ctrl_wdata_i[4]));

   assert_cts_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[0]) |-> $past(status_o[4]) != $past(status_o[4], 2));

   assert_ri_trailing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[2]) |-> $past(status_o[6], 2) && !$past(status_o[6]));

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd_i && $stable(status_o[7:4]) |=> status_o[3:0] == 4'b0000);

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !status_rd_i && irq_o |=> irq_o);
endmodule

bind modem_ctl_stat modem_ctl_stat_chk #(.SYNC_STAGES(SYNC_STAGES), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/modem_ctl_stat_test.sv
`timescale 1ns/1ps
module modem_ctl_stat_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic status_rd = 1'b0;
   logic [3:0] pins = 4'hF;  // {dcd, ri, dsr, cts}
   logic dtr, rts, irq, loopb;
   logic [7:0] status;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // model state
   logic [4:0] m_ctrl = '0;
   logic [3:0] m_prev = '0;
   logic [3:0] m_flags = '0;

   always #2.5 clk = ~clk;

   modem_ctl_stat uut (
      .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
      .status_rd_i(status_rd), .line_cts_i(pins[0]), .line_dsr_i(pins[1]),
      .line_ri_i(pins[2]), .line_dcd_i(pins[3]), .dtr_o(dtr), .rts_o(rts),
      .status_o(status), .irq_o(irq), .loopback_o(loopb)
   );

   function automatic logic [3:0] exp_level(input logic [4:0] c, input logic [3:0] p);
      if (c[4]) return {c[3], c[2], c[0], c[1]};
      return ~p;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      logic [3:0] nl;
      nl = exp_level(m_ctrl, pins);
      m_flags[0] |= nl[0] ^ m_prev[0];
      m_flags[1] |= nl[1] ^ m_prev[1];
      m_flags[3] |= nl[3] ^ m_prev[3];
      m_flags[2] |= m_prev[2] & ~nl[2];
      m_prev = nl;
   endtask

   task automatic check_all();
      chk(m_ctrl[4] ? "R5 loop levels" : "R4 pin levels",
          {4'h0, status[7:4]}, {4'h0, exp_level(m_ctrl, pins)});
      chk("R6 any-edge flags", {5'h0, status[3], status[1:0]},
          {5'h0, m_flags[3], m_flags[1:0]});
      chk("R7 ri flag", {7'h0, status[2]}, {7'h0, m_flags[2]});
      chk("R9 irq", {7'h0, irq}, {7'h0, |m_flags});
      chk("R2 dtr/rts", {6'h0, dtr, rts}, {6'h0, ~m_ctrl[0], ~m_ctrl[1]});
      chk("R3 loopback", {7'h0, loopb}, {7'h0, m_ctrl[4]});
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
      model_step();
      check_all();
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
      m_ctrl = v[4:0];
      settle();
   endtask

   task automatic set_pins(input logic [3:0] v);
      @(negedge clk);
      pins = v;
      settle();
   endtask

   task automatic do_read();
      @(negedge clk);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      m_flags = '0;
      chk("R8 read clears", {4'h0, status[3:0]}, 8'h00);
      check_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", {5'h0, dtr, rts, loopb}, 8'b0000_0110);
      chk("R1 reset flags", {3'h0, irq, status[3:0]}, 8'h00);

      // R3 upper bits ignored
      write_ctrl(8'hE0);
      chk("R3 bits 7..5 ignored", {4'h0, status[3:0]}, 8'h00);

      // R2 pin polarity
      write_ctrl(8'h03);
      write_ctrl(8'h00);

      // R7 ri: high to low gives no flag, low to high does
      set_pins(4'b1011);
      chk("R7 ri falling no flag", {7'h0, status[2]}, 8'h00);
      set_pins(4'b1111);
      chk("R7 ri rising sets flag", {7'h0, status[2]}, 8'h01);
      do_read();

      // R5 loopback routing, pins ignored
      write_ctrl(8'h1D);
      set_pins(4'b0000);
      do_read();
      write_ctrl(8'h12);
      write_ctrl(8'h00);
      do_read();

      // R8 change landing on the read edge is kept
      set_pins(4'b1100);
      @(negedge clk);
      pins = 4'b0100;
      @(negedge clk);
      @(negedge clk);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      m_flags = '0;
      model_step();
      chk("R8 collision keeps flag", {4'h0, status[3:0]}, 8'h08);
      check_all();
      do_read();

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         r = $urandom % 10;
         if (r < 3)      write_ctrl(8'($urandom));
         else if (r < 7) set_pins(4'($urandom));
         else            do_read();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule